// File: doc/BRIEF.md
# Multi-core mailbox doorbell unit

This block holds sixteen 32-bit doorbell mailboxes for a four-core cluster, four owned by each core. Any bus master posts doorbell bits into any mailbox by writing to that mailbox's set alias. The value written is OR-ed into the mailbox. The owning core reads the mailbox through a separate clear alias and acknowledges work by writing ones to that same alias. Because set and clear are distinct write-1 operations, many senders can ring individual bits without a read-modify-write race.

Each core has a small routing register. It enables each of its mailboxes onto that core's IRQ line, its FIQ line, or both. A mailbox requests attention for as long as any of its bits is set. A per-core status word and a flat pending output show which mailboxes are currently non-empty. Access uses a single-cycle register bus. Writes take effect at the clock edge, and read data reflects the current state combinationally.

Top module: `mbx_doorbell_unit`

## Requirements
- R1: After reset every mailbox and every routing register reads zero, and all pending, IRQ and FIQ outputs are low.
- R2: A write to byte address 0x80 + 16*core + 4*mbox ORs the written word into that mailbox; bits written as zero stay unchanged, and writing zero changes nothing.
- R3: A read from byte address 0xC0 + 16*core + 4*mbox returns that mailbox's current contents.
- R4: A write to byte address 0xC0 + 16*core + 4*mbox clears exactly the bits written as one and leaves all other bits.
- R5: The routing register of core n is at byte address 0x50 + 4*n. Bit m enables mailbox m onto IRQ, and bit m+4 enables it onto FIQ. Bits 7:0 read back as written, and the upper bits read zero.
- R6: irq_o[n] is high exactly when some mailbox m of core n is non-zero with routing bit m set, and fiq_o[n] likewise uses bit m+4. The line stays high until the last set bit of every enabled mailbox has been cleared.
- R7: The status word of core n at byte address 0x60 + 4*n has bit 4+m set when mailbox m of that core is non-zero, and all other bits zero. mb_pend_o bit 4*core+mbox carries the same flag.
- R8: Reads from set aliases, from unaligned addresses and from unmapped addresses return zero. Writes to status words, unaligned addresses or unmapped addresses change no state.
- R9: A write to one mailbox leaves every other mailbox unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mb_pend_o | output | 16 | Non-empty flag per mailbox, bit 4*core+mbox |
| irq_o | output | 4 | Per-core IRQ request |
| fiq_o | output | 4 | Per-core FIQ request |

## Verification
The hardest situation to reach is a line that must stay asserted while several unrelated doorbell bits are retired one by one. The bench posts three separate bits into one mailbox with separate writes. It then clears them in an order different from the posting order and confirms that the line falls only on the last clear. Routing is swept through all 256 values of one core's register while two of its mailboxes hold data. After every posting and clearing step, all sixteen mailboxes, all status words and all output lines are compared with an arithmetic model, which also exposes cross-talk between mailboxes.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned CFG_BASE   = 32'h50;
    localparam int unsigned STAT_BASE  = 32'h60;
    localparam int unsigned SET_BASE   = 32'h80;
    localparam int unsigned CLR_BASE   = 32'hC0;
    localparam int unsigned STAT_SHIFT = 4;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_CFG,
        RK_STAT,
        RK_SET,
        RK_CLR
    } rd_kind_e;

endpackage

// File: rtl/mbx_addr_dec.sv
module mbx_addr_dec
    import mbx_pkg::*;
#(
    parameter int NUM_CORES     = 4,
    parameter int MBOX_PER_CORE = 4,
    parameter int ADDR_W        = 8,
    localparam int NSLOT        = NUM_CORES * MBOX_PER_CORE,
    localparam int SLOT_W       = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int CORE_W       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    output logic [NSLOT-1:0]  set_we_o,
    output logic [NSLOT-1:0]  clr_we_o,
    output logic [NUM_CORES-1:0] cfg_we_o,
    output rd_kind_e          rd_kind_o,
    output logic [SLOT_W-1:0] rd_slot_o,
    output logic [CORE_W-1:0] rd_core_o
);

    always_comb begin
        set_we_o  = '0;
        clr_we_o  = '0;
        cfg_we_o  = '0;
        rd_kind_o = RK_NONE;
        rd_slot_o = '0;
        rd_core_o = '0;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (addr_i == ADDR_W'(CFG_BASE + 4 * c)) begin
                rd_kind_o   = RK_CFG;
                rd_core_o   = CORE_W'(c);
                cfg_we_o[c] = we_i;
            end
            if (addr_i == ADDR_W'(STAT_BASE + 4 * c)) begin
                rd_kind_o = RK_STAT;
                rd_core_o = CORE_W'(c);
            end
        end
        for (int k = 0; k < NSLOT; k++) begin
            if (addr_i == ADDR_W'(SET_BASE + 4 * k)) begin
                rd_kind_o   = RK_SET;
                set_we_o[k] = we_i;
            end
            if (addr_i == ADDR_W'(CLR_BASE + 4 * k)) begin
                rd_kind_o   = RK_CLR;
                rd_slot_o   = SLOT_W'(k);
                clr_we_o[k] = we_i;
            end
        end
    end

    // R9: one bus write reaches at most one register
    a_r9_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({set_we_o, clr_we_o, cfg_we_o}));

    // R8: without a write strobe no register is written
    a_r8_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |-> ({set_we_o, clr_we_o, cfg_we_o} == '0));

endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en_i,
    input  logic              clr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] value_o,
    output logic              nonzero_o
);

    typedef struct packed {
        logic [DATA_W-1:0] bits;
    } slot_state_t;

    slot_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en_i) begin
            st_d.bits = st_d.bits & ~wdata_i;
        end
        // set is applied last so it wins on any bit named by both
        if (set_en_i) begin
            st_d.bits = st_d.bits | wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_o   = st_q.bits;
    assign nonzero_o = |st_q.bits;

    a_r2_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        set_en_i |=> ((value_o & $past(wdata_i)) == $past(wdata_i)));

    a_r4_clear_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && !set_en_i) |=> (value_o == ($past(value_o) & ~$past(wdata_i))));

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_en_i && !clr_en_i) |=> $stable(value_o));

endmodule

// File: rtl/mbx_core_ctl.sv
module mbx_core_ctl #(
    parameter int MBOX_PER_CORE = 4,
    localparam int CFG_W        = 2 * MBOX_PER_CORE
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we_i,
    input  logic [CFG_W-1:0]         wdata_i,
    input  logic [MBOX_PER_CORE-1:0] nz_i,
    output logic [CFG_W-1:0]         cfg_o,
    output logic                     irq_o,
    output logic                     fiq_o
);

    typedef struct packed {
        logic [MBOX_PER_CORE-1:0] fiq_en;
        logic [MBOX_PER_CORE-1:0] irq_en;
    } route_t;

    route_t rt_d, rt_q;

    always_comb begin
        rt_d = rt_q;
        if (cfg_we_i) begin
            rt_d = route_t'(wdata_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rt_q <= '0;
        end else begin
            rt_q <= rt_d;
        end
    end

    assign cfg_o = rt_q;
    assign irq_o = |(nz_i & rt_q.irq_en);
    assign fiq_o = |(nz_i & rt_q.fiq_en);

    a_r5_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_i |=> (cfg_o == $past(wdata_i)));

    a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we_i |=> $stable(cfg_o));

    a_r6_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (nz_i == '0) |-> (!irq_o && !fiq_o));

endmodule

// File: rtl/mbx_doorbell_unit.sv
module mbx_doorbell_unit
    import mbx_pkg::*;
#(
    parameter int NUM_CORES     = 4,
    parameter int MBOX_PER_CORE = 4,
    parameter int DATA_W        = 32,
    parameter int ADDR_W        = 8,
    localparam int NSLOT        = NUM_CORES * MBOX_PER_CORE,
    localparam int SLOT_W       = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int CORE_W       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int CFG_W        = 2 * MBOX_PER_CORE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NSLOT-1:0]     mb_pend_o,
    output logic [NUM_CORES-1:0] irq_o,
    output logic [NUM_CORES-1:0] fiq_o
);

    logic [NSLOT-1:0]     set_we;
    logic [NSLOT-1:0]     clr_we;
    logic [NUM_CORES-1:0] cfg_we;
    rd_kind_e             rd_kind;
    logic [SLOT_W-1:0]    rd_slot;
    logic [CORE_W-1:0]    rd_core;

    logic [DATA_W-1:0]    slot_val [NSLOT];
    logic [NSLOT-1:0]     slot_nz;
    logic [CFG_W-1:0]     cfg_val  [NUM_CORES];

    mbx_addr_dec #(
        .NUM_CORES     (NUM_CORES),
        .MBOX_PER_CORE (MBOX_PER_CORE),
        .ADDR_W        (ADDR_W)
    ) dec_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr_i    (bus_addr),
        .we_i      (bus_we),
        .set_we_o  (set_we),
        .clr_we_o  (clr_we),
        .cfg_we_o  (cfg_we),
        .rd_kind_o (rd_kind),
        .rd_slot_o (rd_slot),
        .rd_core_o (rd_core)
    );

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        mbx_slot #(
            .DATA_W (DATA_W)
        ) slot_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_en_i  (set_we[k]),
            .clr_en_i  (clr_we[k]),
            .wdata_i   (bus_wdata),
            .value_o   (slot_val[k]),
            .nonzero_o (slot_nz[k])
        );
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        mbx_core_ctl #(
            .MBOX_PER_CORE (MBOX_PER_CORE)
        ) core_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we_i (cfg_we[c]),
            .wdata_i  (bus_wdata[CFG_W-1:0]),
            .nz_i     (slot_nz[c*MBOX_PER_CORE +: MBOX_PER_CORE]),
            .cfg_o    (cfg_val[c]),
            .irq_o    (irq_o[c]),
            .fiq_o    (fiq_o[c])
        );
    end

    assign mb_pend_o = slot_nz;

    always_comb begin
        bus_rdata = '0;
        unique case (rd_kind)
            RK_CFG:  bus_rdata = DATA_W'(cfg_val[rd_core]);
            RK_STAT: bus_rdata[STAT_SHIFT +: MBOX_PER_CORE] =
                         MBOX_PER_CORE'(slot_nz >> (int'(rd_core) * MBOX_PER_CORE));
            RK_CLR:  bus_rdata = slot_val[rd_slot];
            default: bus_rdata = '0;
        endcase
    end

    // R1: nothing is pending in the first cycle after reset
    a_r1_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mb_pend_o == '0 && irq_o == '0 && fiq_o == '0));

endmodule

// File: tb/mbx_doorbell_unit_tb_top.sv
module mbx_doorbell_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [15:0] mb_pend_o;
    logic [3:0]  irq_o;
    logic [3:0]  fiq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] mdl  [16];
    logic [7:0]  mcfg [4];

    always #2 clk = ~clk;

    mbx_doorbell_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .mb_pend_o (mb_pend_o),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we   = 1'b0;
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [7:0] set_addr(input int k);
        return 8'(8'h80 + 4 * k);
    endfunction

    function automatic logic [7:0] clr_addr(input int k);
        return 8'(8'hC0 + 4 * k);
    endfunction

    task automatic post(input int k, input logic [31:0] v);
        wr(set_addr(k), v);
        mdl[k] = mdl[k] | v;
    endtask

    task automatic ack(input int k, input logic [31:0] v);
        wr(clr_addr(k), v);
        mdl[k] = mdl[k] & ~v;
    endtask

    task automatic route(input int c, input logic [31:0] v);
        wr(8'(8'h50 + 4 * c), v);
        mcfg[c] = v[7:0];
    endtask

    function automatic logic [3:0] core_nz(input int c);
        logic [3:0] r;
        for (int m = 0; m < 4; m++) r[m] = (mdl[4*c+m] != 32'h0);
        return r;
    endfunction

    task automatic check_all();
        logic [31:0] v;
        logic [15:0] pend_exp;
        for (int k = 0; k < 16; k++) begin
            rd(clr_addr(k), v);
            chk("R3", $sformatf("mailbox %0d", k), v, mdl[k]);
            rd(set_addr(k), v);
            chk("R8", $sformatf("set alias %0d read", k), v, 32'h0);
            pend_exp[k] = (mdl[k] != 32'h0);
        end
        chk("R7", "mb_pend_o", 32'(mb_pend_o), 32'(pend_exp));
        for (int c = 0; c < 4; c++) begin
            rd(8'(8'h60 + 4 * c), v);
            chk("R7", $sformatf("status core %0d", c), v, 32'(core_nz(c)) << 4);
            chk("R6", $sformatf("irq core %0d", c), 32'(irq_o[c]),
                32'(|(core_nz(c) & mcfg[c][3:0])));
            chk("R6", $sformatf("fiq core %0d", c), 32'(fiq_o[c]),
                32'(|(core_nz(c) & mcfg[c][7:4])));
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst_n     = 1'b0;
        bus_we    = 1'b0;
        bus_addr  = 8'h0;
        bus_wdata = 32'h0;
        for (int k = 0; k < 16; k++) mdl[k] = 32'h0;
        for (int c = 0; c < 4; c++) mcfg[c] = 8'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #1;
        chk("R1", "irq after reset", 32'(irq_o), 32'h0);
        chk("R1", "fiq after reset", 32'(fiq_o), 32'h0);
        chk("R1", "pend after reset", 32'(mb_pend_o), 32'h0);
        for (int c = 0; c < 4; c++) begin
            rd(8'(8'h50 + 4 * c), v);
            chk("R1", $sformatf("routing core %0d", c), v, 32'h0);
        end
        check_all();

        // R5: routing registers, upper bits dropped
        route(0, 32'h0000_000F);
        route(1, 32'hFFFF_FFF0);
        route(2, 32'h0000_005A);
        route(3, 32'hABCD_EF33);
        for (int c = 0; c < 4; c++) begin
            rd(8'(8'h50 + 4 * c), v);
            chk("R5", $sformatf("routing readback core %0d", c), v, 32'(mcfg[c]));
        end

        // R2, R9: post a distinct pattern into each mailbox, full check each time
        for (int k = 0; k < 16; k++) begin
            post(k, (32'h1 << k) | (32'h8000_0000 >> k));
            check_all();
        end
        // R2: second post ORs, zero write leaves contents
        for (int k = 0; k < 16; k++) begin
            post(k, 32'h00F0_0000 ^ (32'h1 << (k + 8)));
            post(k, 32'h0);
        end
        check_all();

        // R4: clear only some bits of each mailbox
        for (int k = 0; k < 16; k++) begin
            ack(k, 32'h0000_FFFF & mdl[k]);
            check_all();
        end
        for (int k = 0; k < 16; k++) ack(k, 32'hFFFF_FFFF);
        check_all();

        // R6: three senders ring core 2 mailbox 1, acks retire bits one by one
        route(2, 32'h0000_0002);
        post(9, 32'h0000_0008);
        #1 chk("R6", "irq after first post", 32'(irq_o[2]), 32'h1);
        post(9, 32'h0000_0080);
        post(9, 32'h0010_0000);
        ack(9, 32'h0000_0001);
        #1 chk("R6", "irq after ack of unset bit", 32'(irq_o[2]), 32'h1);
        ack(9, 32'h0000_0080);
        #1 chk("R6", "irq after first ack", 32'(irq_o[2]), 32'h1);
        ack(9, 32'h0010_0000);
        #1 chk("R6", "irq after second ack", 32'(irq_o[2]), 32'h1);
        ack(9, 32'h0000_0008);
        #1 chk("R6", "irq after last ack", 32'(irq_o[2]), 32'h0);
        chk("R7", "pend after last ack", 32'(mb_pend_o[9]), 32'h0);
        check_all();

        // R5, R6: exhaustive routing sweep on core 0 with mailboxes 0 and 2 busy
        post(0, 32'h0000_0100);
        post(2, 32'h4000_0000);
        for (int r = 0; r < 256; r++) begin
            route(0, 32'(r));
            #1;
            chk("R6", $sformatf("irq sweep %0d", r), 32'(irq_o[0]),
                32'(|(4'b0101 & 4'(r))));
            chk("R6", $sformatf("fiq sweep %0d", r), 32'(fiq_o[0]),
                32'(|(4'b0101 & 4'(r >> 4))));
        end
        check_all();

        // R8: writes to status, unaligned and unmapped addresses change nothing
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h51, 32'hFFFF_FFFF);
        wr(8'h64, 32'hFFFF_FFFF);
        wr(8'h81, 32'hFFFF_FFFF);
        wr(8'hC2, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h00, v);
        chk("R8", "unmapped read", v, 32'h0);
        rd(8'hC1, v);
        chk("R8", "unaligned read", v, 32'h0);
        for (int c = 0; c < 4; c++) begin
            rd(8'(8'h50 + 4 * c), v);
            chk("R8", $sformatf("routing unchanged core %0d", c), v, 32'(mcfg[c]));
        end
        check_all();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule